// File: doc/BRIEF.md
# Banked Storage Access Guard

This block sits between a byte-wide access port, normally driven by a two-wire serial slave front end, and a 256-byte synchronous storage array. The array is cut into four banks of 64 bytes each, selected by the two upper address bits. Each of the three lower banks carries its own 2-bit protection setting. The setting can block reads, block writes, block both, or leave the bank open. The top bank is never protected.

A read that reaches a read-protected bank returns the fill byte 0xFF and not the stored byte. A write into a write-protected bank still gets a normal acknowledge on the response channel, but the storage is left unchanged. A 16-bit identifier lives at two fixed byte addresses in the top bank, so it can be read even when every lockable bank is sealed. An emulation input lifts read protection while it is high, so a development setup can inspect the contents. It never lifts write protection.

The protection settings are sampled from a configuration bus while reset is held and then stay fixed until the next reset. The storage array has no reset, so its contents survive a reset, as non-volatile contents would.

Top module: `nvm_bank_guard`

## Requirements
- R1: The bank index is address bits [7:6], giving four banks of 64 bytes. In an open bank (or with all settings 00), a byte written to an address is returned by a later read of that address.
- R2: Bank b (b = 0, 1, 2) takes its setting from cfg_lock_i[2b+1:2b], with 00 = open, 01 = read blocked, 10 = write blocked and 11 = both blocked. The setting is captured on every clock edge while rst_n is low, and changes on cfg_lock_i after reset release have no effect.
- R3: Bank 3 (addresses 0xC0 to 0xFF) is always open for reading and writing, whatever the value of cfg_lock_i.
- R4: With emu_i low, a read to a bank whose setting is 01 or 11 returns 0xFF on rsp_rdata_o.
- R5: A write to a bank whose setting is 10 or 11 gets a response with rsp_wack_o high, but the stored byte is not changed.
- R6: With emu_i high at the time a request is accepted, read blocking is not applied and the stored byte is returned. Write blocking still applies.
- R7: The identifier high byte at 0xFE and low byte at 0xFF can be read with their stored values while all three lockable banks are set to 11.
- R8: Every request accepted (req_valid_i and req_ready_o both high at a clock edge) gives exactly one response cycle with rsp_valid_o high, immediately after that edge. A write response has rsp_wack_o = 1 and rsp_rdata_o = 0x00. A read response has rsp_wack_o = 0 and carries the read data. With no request accepted there is no response.
- R9: While rst_n is low, req_ready_o and rsp_valid_o are low. After release, req_ready_o is high from the first clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the protection settings are captured while it is low |
| emu_i | input | 1 | Emulation mode: suspends read protection |
| cfg_lock_i | input | 6 | Protection settings, 2 bits per lockable bank |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte address |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | Response present, one cycle after acceptance |
| rsp_wack_o | output | 1 | Write acknowledge, high for every write response |
| rsp_rdata_o | output | 8 | Read data, or 0xFF for a blocked read |

## Verification
The hardest case to reach from the ports is a write that has been acknowledged but silently dropped. The response itself looks like any other write, and the bank that was written may also block reads, which hides its contents. The stimulus first fills every bank under open settings. It then resets with protection applied and writes into the protected banks. Finally it resets again with open settings and reads the original bytes back. Because the array is not cleared by reset, this sequence shows that the dropped writes never reached storage.

// File: rtl/bank_guard_pkg.sv
package bank_guard_pkg;

   typedef enum logic [1:0] {
      GUARD_OPEN = 2'b00,
      GUARD_RD   = 2'b01,
      GUARD_WR   = 2'b10,
      GUARD_RW   = 2'b11
   } guard_mode_e;

   function automatic logic reads_blocked(input guard_mode_e m);
      return (m == GUARD_RD) || (m == GUARD_RW);
   endfunction

   function automatic logic writes_blocked(input guard_mode_e m);
      return (m == GUARD_WR) || (m == GUARD_RW);
   endfunction

endpackage

// File: rtl/guard_mode_table.sv
module guard_mode_table
   import bank_guard_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int LOCKABLE  = 3,
   parameter int BANK_W    = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2*LOCKABLE-1:0] cfg_i,
   input  logic [BANK_W-1:0]     bank_i,
   output guard_mode_e           mode_o
);

   logic [2*NUM_BANKS-1:0] mode_vec;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      if (b < LOCKABLE) begin : g_lockable
         logic [1:0] mode_q;
         always_ff @(posedge clk) begin
            if (!rst_n) mode_q <= cfg_i[2*b +: 2];
         end
         assign mode_vec[2*b +: 2] = mode_q;
      end else begin : g_open
         assign mode_vec[2*b +: 2] = GUARD_OPEN;
      end
   end

   assign mode_o = guard_mode_e'(mode_vec[2*bank_i +: 2]);

endmodule

// File: rtl/guard_access_filter.sv
module guard_access_filter
   import bank_guard_pkg::*;
(
   input  logic        fire_i,
   input  logic        write_i,
   input  logic        emu_i,
   input  guard_mode_e mode_i,
   output logic        mem_we_o,
   output logic        blank_o
);

   always_comb begin
      mem_we_o = fire_i && write_i && !writes_blocked(mode_i);
      blank_o  = fire_i && !write_i && !emu_i && reads_blocked(mode_i);
   end

endmodule

// File: rtl/guard_store.sv
module guard_store #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) cells[addr_i] <= wdata_i;
      rdata_o <= cells[addr_i];
   end

endmodule

// File: rtl/nvm_bank_guard.sv
module nvm_bank_guard
   import bank_guard_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int          DATA_W   = 8,
   parameter int          BANK_W   = 2,
   parameter int          LOCKABLE = 3,
   parameter logic [7:0]  FILL     = 8'hFF,
   parameter logic [7:0]  ID_ADDR  = 8'hFE
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  emu_i,
   input  logic [2*LOCKABLE-1:0] cfg_lock_i,
   input  logic                  req_valid_i,
   output logic                  req_ready_o,
   input  logic                  req_write_i,
   input  logic [ADDR_W-1:0]     req_addr_i,
   input  logic [DATA_W-1:0]     req_wdata_i,
   output logic                  rsp_valid_o,
   output logic                  rsp_wack_o,
   output logic [DATA_W-1:0]     rsp_rdata_o
);

   localparam int NUM_BANKS = 1 << BANK_W;
   localparam int OFF_W     = ADDR_W - BANK_W;
   localparam int ID_BANK   = int'(ID_ADDR) >> OFF_W;

   if (LOCKABLE >= NUM_BANKS) begin : g_bad_lockable
      $error("LOCKABLE must leave at least one open bank");
   end
   if (ID_BANK < LOCKABLE) begin : g_bad_id
      $error("ID_ADDR must fall in a bank that cannot be locked");
   end
   if (DATA_W != 8) begin : g_bad_width
      $error("FILL and ID_ADDR assume a byte-wide port");
   end

   logic              fire;
   logic              mem_we;
   logic              blank;
   guard_mode_e       mode;
   logic [DATA_W-1:0] mem_q;
   logic              ready_q;
   logic              rsp_valid_q;
   logic              rsp_wack_q;
   logic              blank_q;

   assign fire = req_valid_i && ready_q;

   guard_mode_table #(
      .NUM_BANKS(NUM_BANKS),
      .LOCKABLE (LOCKABLE),
      .BANK_W   (BANK_W)
   ) u_table (
      .clk   (clk),
      .rst_n (rst_n),
      .cfg_i (cfg_lock_i),
      .bank_i(req_addr_i[ADDR_W-1 -: BANK_W]),
      .mode_o(mode)
   );

   guard_access_filter u_filter (
      .fire_i  (fire),
      .write_i (req_write_i),
      .emu_i   (emu_i),
      .mode_i  (mode),
      .mem_we_o(mem_we),
      .blank_o (blank)
   );

   guard_store #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_store (
      .clk    (clk),
      .we_i   (mem_we),
      .addr_i (req_addr_i),
      .wdata_i(req_wdata_i),
      .rdata_o(mem_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q     <= 1'b0;
         rsp_valid_q <= 1'b0;
         rsp_wack_q  <= 1'b0;
         blank_q     <= 1'b0;
      end else begin
         ready_q     <= 1'b1;
         rsp_valid_q <= fire;
         rsp_wack_q  <= fire && req_write_i;
         blank_q     <= blank;
      end
   end

   assign req_ready_o = ready_q;
   assign rsp_valid_o = rsp_valid_q;
   assign rsp_wack_o  = rsp_wack_q;

   always_comb begin
      if (!rsp_valid_q || rsp_wack_q) rsp_rdata_o = '0;
      else if (blank_q)               rsp_rdata_o = FILL;
      else                            rsp_rdata_o = mem_q;
   end

endmodule

// File: rtl/bank_guard_chk.sv
module bank_guard_chk #(
   parameter int         ADDR_W   = 8,
   parameter int         DATA_W   = 8,
   parameter int         BANK_W   = 2,
   parameter int         LOCKABLE = 3,
   parameter logic [7:0] FILL     = 8'hFF
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  emu_i,
   input logic [2*LOCKABLE-1:0] cfg_lock_i,
   input logic                  req_valid_i,
   input logic                  req_ready_o,
   input logic                  req_write_i,
   input logic [ADDR_W-1:0]     req_addr_i,
   input logic                  rsp_valid_o,
   input logic                  rsp_wack_o,
   input logic [DATA_W-1:0]     rsp_rdata_o,
   input logic                  mem_we,
   input logic [ADDR_W-1:0]     mem_addr
);

   localparam int NUM_BANKS = 1 << BANK_W;
   localparam int PAD_W     = 2 * (NUM_BANKS - LOCKABLE);

   logic [2*NUM_BANKS-1:0] cfg_seen;
   logic                   acc;
   logic [BANK_W-1:0]      req_bank;
   logic [BANK_W-1:0]      mem_bank;

   always_ff @(posedge clk) begin
      if (!rst_n) cfg_seen <= {{PAD_W{1'b0}}, cfg_lock_i};
   end

   assign acc      = req_valid_i && req_ready_o;
   assign req_bank = req_addr_i[ADDR_W-1 -: BANK_W];
   assign mem_bank = mem_addr[ADDR_W-1 -: BANK_W];

   // R8
   resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> rsp_valid_o);

   // R8
   no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> !rsp_valid_o);

   // R5
   write_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_write_i) |=> (rsp_wack_o && rsp_rdata_o == '0));

   // R4
   read_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !req_write_i && !emu_i && cfg_seen[2*req_bank]) |=> (rsp_rdata_o == FILL));

   // R5
   write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !cfg_seen[2*mem_bank+1]);

endmodule

bind nvm_bank_guard bank_guard_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .BANK_W  (BANK_W),
   .LOCKABLE(LOCKABLE),
   .FILL    (FILL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .emu_i      (emu_i),
   .cfg_lock_i (cfg_lock_i),
   .req_valid_i(req_valid_i),
   .req_ready_o(req_ready_o),
   .req_write_i(req_write_i),
   .req_addr_i (req_addr_i),
   .rsp_valid_o(rsp_valid_o),
   .rsp_wack_o (rsp_wack_o),
   .rsp_rdata_o(rsp_rdata_o),
   .mem_we     (mem_we),
   .mem_addr   (req_addr_i)
);

// File: tb/tb_nvm_bank_guard.sv
module tb_nvm_bank_guard;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       emu_i = 1'b0;
   logic [5:0] cfg_lock_i = 6'h00;
   logic       req_valid_i = 1'b0;
   logic       req_ready_o;
   logic       req_write_i = 1'b0;
   logic [7:0] req_addr_i = 8'h00;
   logic [7:0] req_wdata_i = 8'h00;
   logic       rsp_valid_o;
   logic       rsp_wack_o;
   logic [7:0] rsp_rdata_o;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   nvm_bank_guard dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .emu_i      (emu_i),
      .cfg_lock_i (cfg_lock_i),
      .req_valid_i(req_valid_i),
      .req_ready_o(req_ready_o),
      .req_write_i(req_write_i),
      .req_addr_i (req_addr_i),
      .req_wdata_i(req_wdata_i),
      .rsp_valid_o(rsp_valid_o),
      .rsp_wack_o (rsp_wack_o),
      .rsp_rdata_o(rsp_rdata_o)
   );

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic apply_reset(input logic [5:0] cfg);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_lock_i = cfg;
      repeat (3) @(negedge clk);
      check(req_ready_o == 1'b0, "R9 ready in reset", int'(req_ready_o), 0);
      check(rsp_valid_o == 1'b0, "R9 rsp in reset", int'(rsp_valid_o), 0);
      rst_n = 1'b1;
      cfg_lock_i = ~cfg;   // R2: later changes must not matter
      @(negedge clk);
      check(req_ready_o == 1'b1, "R9 ready after release", int'(req_ready_o), 1);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d, input string req);
      req_valid_i = 1'b1;
      req_write_i = 1'b1;
      req_addr_i  = a;
      req_wdata_i = d;
      @(negedge clk);
      req_valid_i = 1'b0;
      check(rsp_valid_o && rsp_wack_o && rsp_rdata_o == 8'h00, req,
            int'({rsp_valid_o, rsp_wack_o, rsp_rdata_o}), 'h300);
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
      req_valid_i = 1'b1;
      req_write_i = 1'b0;
      req_addr_i  = a;
      @(negedge clk);
      req_valid_i = 1'b0;
      check(rsp_valid_o && !rsp_wack_o && rsp_rdata_o == exp, req,
            int'({rsp_valid_o, rsp_wack_o, rsp_rdata_o}), int'({2'b10, exp}));
   endtask

   task automatic t_open_banks();
      apply_reset(6'b00_00_00);
      wr(8'h05, 8'hA0, "R1 write bank0");
      wr(8'h45, 8'hA1, "R1 write bank1");
      wr(8'h85, 8'hA2, "R1 write bank2");
      wr(8'hC5, 8'hA3, "R1 write bank3");
      wr(8'hFE, 8'h5A, "R7 write id hi");
      wr(8'hFF, 8'hC3, "R7 write id lo");
      rd(8'h05, 8'hA0, "R2 bank0 open despite later cfg");
      rd(8'h45, 8'hA1, "R1 read bank1");
      rd(8'h85, 8'hA2, "R1 read bank2");
      rd(8'hC5, 8'hA3, "R1 read bank3");
      @(negedge clk);
      check(rsp_valid_o == 1'b0, "R8 no request no response", int'(rsp_valid_o), 0);
   endtask

   task automatic t_mixed_locks();
      // bank0=01 read, bank1=10 write, bank2=11 both
      apply_reset(6'b11_10_01);
      rd(8'h05, 8'hFF, "R4 bank0 read blocked");
      rd(8'h45, 8'hA1, "R2 bank1 write-only lock reads");
      rd(8'h85, 8'hFF, "R4 bank2 read blocked");
      rd(8'hC5, 8'hA3, "R3 bank3 open");
      wr(8'h05, 8'h11, "R2 bank0 write allowed");
      wr(8'h45, 8'h22, "R5 bank1 write acked");
      wr(8'h85, 8'h33, "R5 bank2 write acked");
      rd(8'h45, 8'hA1, "R5 bank1 unchanged");
      emu_i = 1'b1;
      rd(8'h05, 8'h11, "R6 emulation reads bank0");
      rd(8'h85, 8'hA2, "R6 emulation reads bank2");
      wr(8'h45, 8'h55, "R6 emulation write acked");
      rd(8'h45, 8'hA1, "R6 write lock kept in emulation");
      emu_i = 1'b0;
      rd(8'h85, 8'hFF, "R4 blocking back after emulation");
   endtask

   task automatic t_all_sealed();
      apply_reset(6'b11_11_11);
      rd(8'h05, 8'hFF, "R4 sealed bank0");
      rd(8'h45, 8'hFF, "R4 sealed bank1");
      rd(8'hFE, 8'h5A, "R7 id hi readable");
      rd(8'hFF, 8'hC3, "R7 id lo readable");
      wr(8'hC5, 8'h44, "R3 bank3 write");
      rd(8'hC5, 8'h44, "R3 bank3 stored");
      wr(8'h05, 8'h99, "R5 sealed write acked");
   endtask

   task automatic t_readback();
      apply_reset(6'b00_00_00);
      rd(8'h05, 8'h11, "R5 bank0 kept value");
      rd(8'h45, 8'hA1, "R5 bank1 kept value");
      rd(8'h85, 8'hA2, "R5 bank2 kept value");
      wr(8'h46, 8'h6B, "R8 back-to-back write");
      rd(8'h46, 8'h6B, "R8 back-to-back read");
   endtask

   initial begin
      fork
         begin
            t_open_banks();
            t_mixed_locks();
            t_all_sealed();
            t_readback();
         end
         begin
            repeat (20000) @(posedge clk);
            check(1'b0, "watchdog", 0, 1);
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule